// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial frames made of one low start bit, eight data bits sent least significant first and one stop bit. The serial line is watched at sixteen times the bit rate through a one-cycle tick enable supplied from outside. The line first passes through a two-flop synchroniser. While idle, the block looks for a high-to-low change between consecutive tick samples. When it sees one, it presets its 9-bit assembly register to all ones and restarts its sixteen-state phase counter, so that counter rollovers fall on the incoming bit boundaries.

Each bit is decided by a 2-of-3 vote over the samples taken when the counter enters states 7, 8 and 9. If the vote on the first bit is not low, the frame is dropped as a false start and the receiver goes back to waiting for an edge. Voted bits enter the assembly register at the right end, and the preset ones leave at the left end. Once the start bit has reached the leftmost cell, the next voted bit is taken as the stop bit and the frame ends.

A completed frame loads the data byte and the stop bit value into output registers and raises a done flag. The flag stays set until a clear pulse arrives. A frame that completes while the flag is still set is thrown away and flags an overrun instead.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, rx_done = 0, rx_overrun = 0, rx_byte = 8'h00 and rx_stop = 0.
- R2: The receiver counts tick samples from the detecting tick (state 0) and decides each bit on the tick at which its counter enters state 9. In particular, rx_done rises in the clock after the tick at which the counter enters state 9 of the tenth bit time (stop bit), and not one tick before it.
- R3: A bit is decided by majority over the synchronised line at counter states 7, 8 and 9. A disturbance confined to one of these samples does not change the bit, and a disturbance covering two of them inverts it.
- R4: If the vote on the start bit is 1, no frame is delivered (rx_done stays 0), and a falling edge that follows is received as a new frame.
- R5: The data bits are received least significant first: rx_byte[i] is the (i+1)-th bit after the start bit, for every byte value.
- R6: rx_stop holds the voted value of the bit that follows the eighth data bit. A frame with a low stop bit still delivers its byte, with rx_stop = 0.
- R7: On completion with rx_done clear, rx_done is set, and it stays set until clr_done is high for one cycle, which clears it.
- R8: A frame that completes while rx_done is set leaves rx_byte and rx_stop unchanged and sets rx_overrun. clr_done clears rx_overrun.
- R9: Falling edges on the line during a frame do not restart reception, so a byte with alternating bits is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| clr_done | input | 1 | Clears the done and overrun flags |
| rx_byte | output | 8 | Last accepted data byte |
| rx_stop | output | 1 | Voted stop bit of the last accepted frame |
| rx_done | output | 1 | A received byte is waiting |
| rx_overrun | output | 1 | A frame was dropped because rx_done was set |

## Verification
Every one of the 256 byte values is sent as a clean frame. This separates correct least-significant-first assembly and stop capture from swapped, shifted or stuck bits. Frames carrying a one-tick and a two-tick inversion inside the voting window tell a true 2-of-3 vote apart from single-point sampling. A runt low pulse and a start bit that fails the vote show whether false starts are rejected. A stop-bit timing probe and back-to-back frames without a clear check where the decision point falls, and that an unread byte is protected while an overrun is reported.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;

    localparam int unsigned UMV_DATA_BITS = 8;
    localparam int unsigned UMV_OVS       = 16;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic value;
    } vote_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= 2'b11;
        else     stage <= {stage[0], din};
    end

    assign dout = stage[1];
endmodule

// File: rtl/uart_mv_voter.sv
module uart_mv_voter
    import uart_mv_pkg::*;
#(
    parameter int unsigned OVS = UMV_OVS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  active,
    input  logic  restart,
    input  logic  line,
    output vote_t vote
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned MID   = OVS / 2;
    localparam logic [CNT_W-1:0] ST_A = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] ST_B = CNT_W'(MID);
    localparam logic [CNT_W-1:0] ST_C = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] phase_nxt;
    logic             smp_a;
    logic             smp_b;
    logic             step;

    assign phase_nxt = (phase == ST_LAST) ? '0 : phase + 1'b1;
    assign step      = tick & active;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (restart) begin
            phase <= '0;
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (step) begin
            phase <= phase_nxt;
            if (phase_nxt == ST_A) smp_a <= line;
            if (phase_nxt == ST_B) smp_b <= line;
        end
    end

    always_comb begin
        vote.valid = step & (phase_nxt == ST_C);
        vote.value = maj3(smp_a, smp_b, line);
    end
endmodule

// File: rtl/uart_mv_shreg.sv
module uart_mv_shreg #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 preset,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic                 left_bit,
    output logic [DATA_BITS-1:0] data_out
);
    localparam int unsigned SR_W = DATA_BITS + 1;

    logic [SR_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)           sr <= '1;
        else if (preset)   sr <= '1;
        else if (shift_en) sr <= {sr[SR_W-2:0], bit_in};
    end

    assign left_bit = sr[SR_W-1];

    for (genvar i = 0; i < DATA_BITS; i++) begin : g_rev
        assign data_out[i] = sr[DATA_BITS-1-i];
    end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
    import uart_mv_pkg::*;
#(
    parameter int unsigned DATA_BITS = UMV_DATA_BITS,
    parameter int unsigned OVS       = UMV_OVS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick16,
    input  logic                 rxd,
    input  logic                 clr_done,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_stop,
    output logic                 rx_done,
    output logic                 rx_overrun
);
    rx_state_e            state;
    logic                 line_s;
    logic                 last_s;
    logic                 fall;
    logic                 active;
    vote_t                vote;
    logic                 vote_valid;
    logic                 vote_value;
    logic                 left_bit;
    logic                 shift_en;
    logic                 complete;
    logic [DATA_BITS-1:0] asm_data;

    uart_mv_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    assign fall   = tick16 & (state == RX_IDLE) & last_s & ~line_s;
    assign active = (state != RX_IDLE);

    uart_mv_voter #(.OVS(OVS)) u_voter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .active  (active),
        .restart (fall),
        .line    (line_s),
        .vote    (vote)
    );

    assign vote_valid = vote.valid;
    assign vote_value = vote.value;

    assign shift_en = vote_valid &
                      (((state == RX_START) & ~vote_value) |
                       ((state == RX_DATA) & left_bit));
    assign complete = vote_valid & (state == RX_DATA) & ~left_bit;

    uart_mv_shreg #(.DATA_BITS(DATA_BITS)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .preset   (fall),
        .shift_en (shift_en),
        .bit_in   (vote_value),
        .left_bit (left_bit),
        .data_out (asm_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            last_s <= 1'b1;
        end else begin
            if (tick16) last_s <= line_s;
            case (state)
                RX_IDLE:  if (fall) state <= RX_START;
                RX_START: if (vote_valid) state <= vote_value ? RX_IDLE : RX_DATA;
                RX_DATA:  if (complete) state <= RX_IDLE;
                default:  state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte    <= '0;
            rx_stop    <= 1'b0;
            rx_done    <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (clr_done) begin
                rx_done    <= 1'b0;
                rx_overrun <= 1'b0;
            end
            if (complete) begin
                if (!rx_done || clr_done) begin
                    rx_byte <= asm_data;
                    rx_stop <= vote_value;
                    rx_done <= 1'b1;
                end else begin
                    rx_overrun <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_mv_chk.sv
module uart_mv_chk
    import uart_mv_pkg::*;
#(
    parameter int unsigned DATA_BITS = UMV_DATA_BITS
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_done,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 rx_done,
    input logic                 rx_overrun,
    input rx_state_e            state,
    input logic                 vote_valid,
    input logic                 vote_value
);
    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !clr_done) |=> rx_done);

    assert_byte_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !clr_done) |=> $stable(rx_byte));

    assert_clear_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        clr_done |=> !rx_overrun);

    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_done));

    assert_false_start_R4: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && vote_valid && vote_value) |=> (state == RX_IDLE));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA && !vote_valid) |=> (state == RX_DATA));
endmodule

bind uart_mv_rx uart_mv_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_done   (clr_done),
    .rx_byte    (rx_byte),
    .rx_done    (rx_done),
    .rx_overrun (rx_overrun),
    .state      (state),
    .vote_valid (vote_valid),
    .vote_value (vote_value)
);

// File: tb/sim_uart_mv_rx.sv
module sim_uart_mv_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int SLOTS      = 16;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       clr_done = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_done;
    logic       rx_overrun;

    int checks = 0;
    int failures = 0;
    int tdiv = 0;
    int cycles = 0;
    bit finished = 0;

    uart_mv_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .tick16     (tick16),
        .rxd        (rxd),
        .clr_done   (clr_done),
        .rx_byte    (rx_byte),
        .rx_stop    (rx_stop),
        .rx_done    (rx_done),
        .rx_overrun (rx_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV-1);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1;
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!tick16);
        #1;
    endtask

    // slot s of a frame: bit (s/16); glitch slots invert the line
    task automatic frame_slots(input logic [9:0] bits, input int g0, input int g1,
                               input int first, input int last);
        for (int s = first; s <= last; s++) begin
            rxd = bits[s / SLOTS] ^ ((s == g0) || (s == g1));
            wait_tick();
        end
    endtask

    task automatic send(input logic [7:0] d, input logic stp, input int g0, input int g1);
        frame_slots({stp, d, 1'b0}, g0, g1, 0, 10*SLOTS-1);
        rxd = 1'b1;
        wait_tick();
        wait_tick();
    endtask

    task automatic clear();
        clr_done = 1'b1;
        @(posedge clk);
        #1;
        clr_done = 1'b0;
        wait_tick();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(rx_done == 0 && rx_overrun == 0, "R1 flags", {rx_done, rx_overrun}, 0);
        check(rx_byte == 8'h00 && rx_stop == 0, "R1 data", {rx_stop, rx_byte}, 0);
        wait_tick();
        wait_tick();

        // R5 R6 R7: sweep of every byte value
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b1, -1, -1);
            @(negedge clk);
            check(rx_done == 1, "R7 done", rx_done, 1);
            check(rx_byte == 8'(v), "R5 byte", rx_byte, v);
            check(rx_stop == 1, "R6 stop", rx_stop, 1);
            clear();
            @(negedge clk);
            check(rx_done == 0, "R7 clear", rx_done, 0);
            wait_tick();
        end

        // R2: decision timing of stop bit (counter state 9 of bit 9)
        frame_slots({1'b1, 8'h3C, 1'b0}, -1, -1, 0, 9*SLOTS+8);
        @(negedge clk);
        check(rx_done == 0, "R2 early", rx_done, 0);
        frame_slots({1'b1, 8'h3C, 1'b0}, -1, -1, 9*SLOTS+9, 9*SLOTS+9);
        @(negedge clk);
        check(rx_done == 1, "R2 on time", rx_done, 1);
        frame_slots({1'b1, 8'h3C, 1'b0}, -1, -1, 9*SLOTS+10, 10*SLOTS-1);
        rxd = 1'b1;
        wait_tick();
        clear();

        // R3: one sample disturbed in data bit 2 (frame bit 3)
        send(8'hA5, 1'b1, 3*SLOTS+8, -1);
        @(negedge clk);
        check(rx_byte == 8'hA5, "R3 single glitch", rx_byte, 8'hA5);
        clear();
        send(8'hA5, 1'b1, 3*SLOTS+7, -1);
        @(negedge clk);
        check(rx_byte == 8'hA5, "R3 early glitch", rx_byte, 8'hA5);
        clear();
        // R3: two samples disturbed invert the bit
        send(8'hA5, 1'b1, 3*SLOTS+8, 3*SLOTS+9);
        @(negedge clk);
        check(rx_byte == (8'hA5 ^ 8'h04), "R3 double glitch", rx_byte, 8'hA5 ^ 8'h04);
        clear();

        // R4: runt low pulse of four slots
        for (int s = 0; s < 4; s++) begin rxd = 1'b0; wait_tick(); end
        for (int s = 0; s < 170; s++) begin rxd = 1'b1; wait_tick(); end
        @(negedge clk);
        check(rx_done == 0, "R4 runt rejected", rx_done, 0);
        // R4: low only at state 7 of the start bit, vote gives 1
        for (int s = 0; s < 8; s++) begin rxd = 1'b0; wait_tick(); end
        for (int s = 0; s < 170; s++) begin rxd = 1'b1; wait_tick(); end
        @(negedge clk);
        check(rx_done == 0, "R4 vote rejected", rx_done, 0);
        send(8'h96, 1'b1, -1, -1);
        @(negedge clk);
        check(rx_done == 1 && rx_byte == 8'h96, "R4 recovery", rx_byte, 8'h96);
        clear();

        // R6: low stop bit still delivers
        send(8'h71, 1'b0, -1, -1);
        @(negedge clk);
        check(rx_byte == 8'h71 && rx_done == 1, "R6 byte low stop", rx_byte, 8'h71);
        check(rx_stop == 0, "R6 low stop", rx_stop, 0);
        clear();

        // R9: alternating bits contain many falling edges
        send(8'h55, 1'b1, -1, -1);
        @(negedge clk);
        check(rx_byte == 8'h55, "R9 alternating", rx_byte, 8'h55);

        // R7: flag holds while idle; R8: second frame dropped
        for (int s = 0; s < 40; s++) wait_tick();
        @(negedge clk);
        check(rx_done == 1, "R7 hold", rx_done, 1);
        send(8'hC3, 1'b0, -1, -1);
        @(negedge clk);
        check(rx_overrun == 1, "R8 overrun", rx_overrun, 1);
        check(rx_byte == 8'h55 && rx_stop == 1, "R8 kept", {rx_stop, rx_byte}, 9'h155);
        clear();
        @(negedge clk);
        check(rx_overrun == 0 && rx_done == 0, "R8 clear", {rx_done, rx_overrun}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule